// File: doc/BRIEF.md
# Channel Attenuation Combiner with Mute

This block turns a per-channel volume and a per-side master volume into one analog attenuation code for a single DAC channel. It then hands that code to a codec register write port as two writes.

The channel volume and the master volume are each 7 bits wide, and 127 means 0 dB. The block multiplies the two and divides the product by 127. It then maps the quotient through a 256-entry logarithmic table. The first write carries the plain code, and the second write carries the same code with the latch and update-all bits set. Left and right sides have separate master settings. The low bit of the channel register index picks which one applies.

The control is a five-state machine:
- `ST_IDLE` waits for `start` and captures all inputs (transition IDLE→SCALE).
- `ST_SCALE` registers the scaled quotient (SCALE→MAP).
- `ST_MAP` registers the mapped code (MAP→LATCH).
- `ST_LATCH` requests the first write and holds until it is acknowledged (LATCH→UPDATE on `wr_ack`).
- `ST_UPDATE` requests the second write and holds until it is acknowledged (UPDATE→IDLE on `wr_ack`). This transition raises `done` for one cycle.

Top module: `chan_atten_writer`

## Requirements
- R1: After reset, `busy`, `wr_req` and `done` are all 0.
- R2: If the channel mute flag or the selected master mute flag is 1, the attenuation code is 0. Both writes then carry 7-bit code 0, so the data words are 0x000 and 0x180.
- R3: When unmuted, the table index equals floor(channel_vol × master_vol / 127).
- R4: The code equals 127 minus the table entry. The entry for index x ≥ 1 is 20·log10(255/x) rounded to the nearest integer, and the entry for index 0 is 127, so index 0 gives code 0.
- R5: With both volumes at 127, the index is 127 and the code is 121.
- R6: Each update issues two writes, and both go to `wr_addr` equal to the captured `reg_index`. The first has `wr_data` = {2'b00, code}. The second has `wr_data` = {2'b11, code}, that is, the code OR 0x180.
- R7: An even `reg_index` (bit 0 = 0) uses `left_vol`/`left_mute`. An odd `reg_index` uses `right_vol`/`right_mute`. The other side's values have no effect.
- R8: While `busy` is 1, `start` is ignored: `wr_addr` and the write sequence already in progress are unchanged, and no further write follows it.
- R9: `done` is 1 for exactly one cycle, in the cycle after the second write's acknowledge is sampled. `wr_req` is 0 in that cycle.
- R10: While `wr_req` is 1 and `wr_ack` is 0, the request stays asserted and `wr_data`/`wr_addr` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one update; sampled only when idle |
| reg_index | input | 7 | Channel register address; bit 0 selects the side |
| chan_vol | input | 7 | Channel volume, 0..127 |
| chan_mute | input | 1 | Channel mute flag |
| left_vol | input | 7 | Left-side master volume |
| left_mute | input | 1 | Left-side master mute |
| right_vol | input | 7 | Right-side master volume |
| right_mute | input | 1 | Right-side master mute |
| wr_ack | input | 1 | Write acknowledge from the codec port |
| busy | output | 1 | Update sequence in progress |
| wr_req | output | 1 | Write request |
| wr_addr | output | 7 | Register address of the write |
| wr_data | output | 9 | Write data word |
| done | output | 1 | One-cycle pulse after the second acknowledge |

## Verification
The assertions assume that `wr_ack` is a single-cycle pulse raised only while `wr_req` is 1. They also assume that the volume inputs stay within 0..127, which the 7-bit ports guarantee. The bench plays the codec port and acknowledges each request exactly once, for one cycle, sometimes after several idle cycles. It changes inputs and pulses `start` only on falling clock edges, including while a sequence is in flight. This exercises the ignore rule without breaking the acknowledge assumption.

// File: rtl/atten_pkg.sv
package atten_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCALE,
        ST_MAP,
        ST_LATCH,
        ST_UPDATE
    } wr_state_e;

    // Rounded 20*log10(ref/x); index 0 maps to the deepest code.
    function automatic int log_att(input int x, input int ref_level, input int deepest);
        real v;
        if (x == 0) begin
            return deepest;
        end
        v = 20.0 * $log10(real'(ref_level) / real'(x));
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/atten_scale.sv
module atten_scale #(
    parameter int VOL_W = 7,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [VOL_W-1:0] vol_a,
    input  logic [VOL_W-1:0] vol_b,
    output logic [IDX_W-1:0] quot
);
    localparam int FULL   = (1 << VOL_W) - 1;
    localparam int PROD_W = 2 * VOL_W;
    localparam int SHIFT  = PROD_W + 7;
    localparam int RECIP  = ((1 << SHIFT) + FULL - 1) / FULL;
    localparam int WIDE_W = SHIFT + PROD_W + 1;

    logic [PROD_W-1:0] prod;
    logic [WIDE_W-1:0] wide;

    assign prod = PROD_W'(vol_a) * PROD_W'(vol_b);
    assign wide = WIDE_W'(prod) * WIDE_W'(RECIP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot <= '0;
        end else if (en) begin
            quot <= IDX_W'(wide >> SHIFT);
        end
    end

    // Registered quotient is the exact floor of the product over full scale.
    assert_exact_divide_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((int'(quot) * FULL <= int'($past(prod))) &&
                (int'($past(prod)) < int'(quot) * FULL + FULL)));

endmodule

// File: rtl/atten_rom.sv
module atten_rom #(
    parameter int VOL_W = 7,
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [VOL_W-1:0] entry
);
    localparam int DEPTH     = 1 << IDX_W;
    localparam int REF_LEVEL = DEPTH - 1;
    localparam int DEEPEST   = (1 << VOL_W) - 1;

    logic [VOL_W-1:0] table_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam int E = atten_pkg::log_att(g, REF_LEVEL, DEEPEST);
        assign table_q[g] = VOL_W'(E);
    end

    assign entry = table_q[idx];

endmodule

// File: rtl/chan_atten_writer.sv
module chan_atten_writer #(
    parameter int VOL_W  = 7,
    parameter int ADDR_W = 7,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] reg_index,
    input  logic [VOL_W-1:0]  chan_vol,
    input  logic              chan_mute,
    input  logic [VOL_W-1:0]  left_vol,
    input  logic              left_mute,
    input  logic [VOL_W-1:0]  right_vol,
    input  logic              right_mute,
    input  logic              wr_ack,
    output logic              busy,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [VOL_W+1:0]  wr_data,
    output logic              done
);
    import atten_pkg::*;

    localparam int          FULL     = (1 << VOL_W) - 1;
    localparam logic [1:0]  UPD_BITS = 2'b11;

    wr_state_e         state, state_nx;
    logic [VOL_W-1:0]  cvol_q, mvol_q, code_q, entry;
    logic              mute_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  quot;

    atten_scale #(.VOL_W(VOL_W), .IDX_W(IDX_W)) u_scale (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_SCALE),
        .vol_a (cvol_q),
        .vol_b (mvol_q),
        .quot  (quot)
    );

    atten_rom #(.VOL_W(VOL_W), .IDX_W(IDX_W)) u_rom (
        .idx   (quot),
        .entry (entry)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_SCALE;
            ST_SCALE:  state_nx = ST_MAP;
            ST_MAP:    state_nx = ST_LATCH;
            ST_LATCH:  if (wr_ack) state_nx = ST_UPDATE;
            ST_UPDATE: if (wr_ack) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cvol_q <= '0;
            mvol_q <= '0;
            mute_q <= 1'b0;
            addr_q <= '0;
            code_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= (state == ST_UPDATE) && wr_ack;
            if (state == ST_IDLE && start) begin
                addr_q <= reg_index;
                cvol_q <= chan_vol;
                if (reg_index[0]) begin
                    mvol_q <= right_vol;
                    mute_q <= chan_mute | right_mute;
                end else begin
                    mvol_q <= left_vol;
                    mute_q <= chan_mute | left_mute;
                end
            end
            if (state == ST_MAP) begin
                code_q <= mute_q ? '0 : VOL_W'(FULL) - entry;
            end
        end
    end

    // Outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        wr_req  = (state == ST_LATCH) || (state == ST_UPDATE);
        wr_addr = addr_q;
        wr_data = (state == ST_UPDATE) ? {UPD_BITS, code_q} : {2'b00, code_q};
    end

    assert_mute_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && mute_q) |-> (wr_data[VOL_W-1:0] == '0));

    assert_second_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && wr_ack) |=>
            (wr_req && wr_data == ($past(wr_data) | 9'h180) && wr_addr == $past(wr_addr)));

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wr_addr));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE && wr_ack) |=> (done && !wr_req));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_data)));

endmodule

// File: tb/sim_chan_atten_writer.sv
`timescale 1ns/1ps
module sim_chan_atten_writer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] reg_index = '0;
    logic [6:0] chan_vol = '0;
    logic       chan_mute = 1'b0;
    logic [6:0] left_vol = '0;
    logic       left_mute = 1'b0;
    logic [6:0] right_vol = '0;
    logic       right_mute = 1'b0;
    logic       wr_ack = 1'b0;
    logic       busy, wr_req, done;
    logic [6:0] wr_addr;
    logic [8:0] wr_data;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    chan_atten_writer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_index(reg_index),
        .chan_vol(chan_vol), .chan_mute(chan_mute),
        .left_vol(left_vol), .left_mute(left_mute),
        .right_vol(right_vol), .right_mute(right_mute),
        .wr_ack(wr_ack), .busy(busy), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    typedef struct packed {
        logic [6:0] cv; logic cm;
        logic [6:0] lv; logic lm;
        logic [6:0] rv; logic rm;
        logic [6:0] idx;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{cv:7'd127, cm:1'b0, lv:7'd127, lm:1'b0, rv:7'd0,   rm:1'b1, idx:7'd0},
        '{cv:7'd64,  cm:1'b0, lv:7'd100, lm:1'b0, rv:7'd0,   rm:1'b0, idx:7'd2},
        '{cv:7'd1,   cm:1'b0, lv:7'd1,   lm:1'b0, rv:7'd127, rm:1'b0, idx:7'd4},
        '{cv:7'd127, cm:1'b0, lv:7'd0,   lm:1'b1, rv:7'd127, rm:1'b0, idx:7'd1},
        '{cv:7'd127, cm:1'b1, lv:7'd127, lm:1'b0, rv:7'd127, rm:1'b0, idx:7'd3},
        '{cv:7'd127, cm:1'b0, lv:7'd127, lm:1'b1, rv:7'd5,   rm:1'b0, idx:7'd6},
        '{cv:7'd50,  cm:1'b0, lv:7'd127, lm:1'b0, rv:7'd127, rm:1'b0, idx:7'd7},
        '{cv:7'd100, cm:1'b0, lv:7'd0,   lm:1'b1, rv:7'd3,   rm:1'b0, idx:7'd5}
    };

    // Model built from R2, R3, R4 and R7
    function automatic int model_code(vec_t v);
        int mv, q, e;
        logic mute;
        mv   = v.idx[0] ? int'(v.rv) : int'(v.lv);
        mute = v.cm | (v.idx[0] ? v.rm : v.lm);
        if (mute) return 0;
        q = (int'(v.cv) * mv) / 127;
        if (q == 0) e = 127;
        else e = $rtoi(20.0 * $log10(255.0 / real'(q)) + 0.5);
        return 127 - e;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_req();
        for (int n = 0; n < 50 && !wr_req; n++) @(negedge clk);
    endtask

    task automatic launch(vec_t v);
        @(negedge clk);
        reg_index = v.idx; chan_vol = v.cv; chan_mute = v.cm;
        left_vol = v.lv; left_mute = v.lm; right_vol = v.rv; right_mute = v.rm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(vec_t v, input int ack_delay, input string tag);
        int exp;
        exp = model_code(v);
        launch(v);
        wait_req();
        check({tag, " req1"}, wr_req, 1);
        check({tag, " addr1 R6"}, wr_addr, v.idx);
        check({tag, " data1 R6"}, wr_data, exp);
        for (int d = 0; d < ack_delay; d++) begin
            @(negedge clk);
            check("R10 req held", wr_req, 1);
            check("R10 data held", wr_data, exp);
        end
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        check({tag, " addr2 R6"}, wr_addr, v.idx);
        check({tag, " data2 R6"}, wr_data, exp | 9'h180);
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
        check("R9 done high", done, 1);
        check("R9 req low at done", wr_req, 0);
        @(negedge clk);
        check("R9 done one cycle", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 req", wr_req, 0);
        check("R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after release", busy, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], 0, "R2 R3 R4 R7 vector");
        end

        // R5: full scale gives code 121
        v = '{cv:7'd127, cm:1'b0, lv:7'd127, lm:1'b0, rv:7'd0, rm:1'b0, idx:7'd8};
        check("R5 full scale model", model_code(v), 121);
        run_vec(v, 0, "R5");

        // R2: master mute on selected side, odd index
        v = '{cv:7'd90, cm:1'b0, lv:7'd127, lm:1'b0, rv:7'd127, rm:1'b1, idx:7'd9};
        check("R2 mute model", model_code(v), 0);
        run_vec(v, 0, "R2");

        // R10: delayed acknowledge
        v = '{cv:7'd30, cm:1'b0, lv:7'd80, lm:1'b0, rv:7'd0, rm:1'b0, idx:7'd10};
        run_vec(v, 4, "R10");

        // R8: start ignored while busy
        v = '{cv:7'd127, cm:1'b0, lv:7'd60, lm:1'b0, rv:7'd0, rm:1'b0, idx:7'd12};
        launch(v);
        reg_index = 7'd33; chan_mute = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_req();
        check("R8 addr kept", wr_addr, 12);
        check("R8 data kept", wr_data, model_code(v));
        wr_ack = 1'b1; @(negedge clk); wr_ack = 1'b0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        check("R8 data2 kept", wr_data, model_code(v) | 9'h180);
        wr_ack = 1'b1; @(negedge clk); wr_ack = 1'b0;
        check("R8 done", done, 1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R8 no extra write", wr_req, 0);
        end
        check("R8 idle", busy, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule